// File: doc/BRIEF.md
# Sixty-Four-Source Vectored Interrupt Controller

This block gathers up to 64 level-sensitive interrupt request lines into two 32-bit register banks, called the high bank and the low bank. Each bank has an enable word and a pending word. A source is placed in a bank and at a bit position by a fixed scattered mapping, not by its vector number. Software enables sources through the enable words and acknowledges them by writing ones to the pending words.

From the pending and enabled sources, a fixed-priority picker selects the lowest vector number, starting at 1. It reports that vector in the top six bits of a read-only vector register and raises a single interrupt line to the processor. A simple synchronous register bus gives access to the block. Writes take effect at a clock edge, and reads return data combinationally from the current register state.

Top module: `irqv_ctrl`

## Requirements
- R1: After reset, both enable words and both pending words read 0x00000000, the vector register reads 0, and `irq_o` is low.
- R2: Vectors 0–15 and 32–47 are held in the high bank. Vectors 16–31 and 48–63 are held in the low bank.
- R3: Bit positions inside a bank follow a fixed mapping. Vector 0 uses bit 0, and vector v in 1–15 uses bit 16−v. Vector 16 uses bit 2, vector 17 uses bit 1, vector v in 18–30 uses bit 33−v, and vector 31 uses bit 0. Vector v in 32–47 uses bit 63−v. Vector v in 48–63 uses bit v−32.
- R4: The enable words are at byte offset 0x00 (high) and 0x04 (low). A write loads the whole word and a read returns it. A bit at 1 enables its source.
- R5: The pending words are at 0x08 (high) and 0x0C (low). A pending bit becomes 1 on the clock edge where its source input is high, whether or not the source is enabled.
- R6: Writing a 1 to a pending bit clears it. Writing a 0 to a pending bit leaves it unchanged, even when its source is low.
- R7: Sources are level-sensitive. If a clearing write lands while the source is still high, the pending bit stays 1.
- R8: The vector register at 0x10 returns the selected vector in bits 31:26 and zeros in bits 25:0. The selected vector is the lowest-numbered vector from 1 to 63 that is both pending and enabled, or 0 if there is none. Reading it has no side effects.
- R9: `irq_o` is high exactly when some vector from 1 to 63 is both pending and enabled. Vector 0 is never selected and never raises `irq_o`.
- R10: Writes to 0x10, or to any offset other than the four enable and pending words, change no state. Reads from unmapped offsets return 0.
- R11: A source that goes high is reflected in the pending word, the vector and `irq_o` after exactly one rising clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Level request lines, bit n is vector n |
| wr_en_i | input | 1 | Write strobe for the register bus |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that the request lines and bus inputs are synchronous to `clk_i` and stable around its rising edge. They also assume that `addr_i` is a known value whenever `wr_en_i` is high. The bench meets these assumptions by changing every input only on the falling edge. It reads registers a short delay after that edge and asserts a write strobe for exactly one rising edge. The bench never raises a request line during reset.

// File: rtl/irqv_pkg.sv
`timescale 1ns/1ps
package irqv_pkg;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = WORD_W / 2;
    localparam int NUM_VEC = 2 * WORD_W;
    localparam int VEC_W   = $clog2(NUM_VEC);
    localparam int VEC_LSB = WORD_W - VEC_W;
    localparam int ADDR_W  = 5;

    localparam logic [ADDR_W-1:0] OFS_EN_HI   = ADDR_W'(5'h00);
    localparam logic [ADDR_W-1:0] OFS_EN_LO   = ADDR_W'(5'h04);
    localparam logic [ADDR_W-1:0] OFS_PEND_HI = ADDR_W'(5'h08);
    localparam logic [ADDR_W-1:0] OFS_PEND_LO = ADDR_W'(5'h0C);
    localparam logic [ADDR_W-1:0] OFS_VEC     = ADDR_W'(5'h10);

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t en_hi;
        word_t en_lo;
        word_t pend_hi;
        word_t pend_lo;
    } ctl_state_t;

    // vectors in the first and third quarter live in the high bank
    function automatic bit vec_in_hi(input int v);
        return ((v / HALF_W) % 2) == 0;
    endfunction

    // scattered bit position of a vector inside its bank
    function automatic int vec_bitpos(input int v);
        int pos;
        if (v < HALF_W) begin
            pos = (v == 0) ? 0 : HALF_W - v;
        end else if (v < WORD_W) begin
            if (v == HALF_W)           pos = 2;
            else if (v == HALF_W + 1)  pos = 1;
            else if (v == WORD_W - 1)  pos = 0;
            else                       pos = WORD_W + 1 - v;
        end else if (v < WORD_W + HALF_W) begin
            pos = 2 * WORD_W - 1 - v;
        end else begin
            pos = v - WORD_W;
        end
        return pos;
    endfunction
endpackage

// File: rtl/irqv_map.sv
`timescale 1ns/1ps
module irqv_map
    import irqv_pkg::*;
(
    input  logic [NUM_VEC-1:0] src_i,
    input  word_t              act_hi_i,
    input  word_t              act_lo_i,
    output word_t              src_hi_o,
    output word_t              src_lo_o,
    output logic [NUM_VEC-1:0] act_o
);
    // scatter request lines into banks, gather bank words back into vector order
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        localparam int BP = vec_bitpos(v);
        if (vec_in_hi(v)) begin : g_hi
            assign src_hi_o[BP] = src_i[v];
            assign act_o[v]     = act_hi_i[BP];
        end else begin : g_lo
            assign src_lo_o[BP] = src_i[v];
            assign act_o[v]     = act_lo_i[BP];
        end
    end
endmodule

// File: rtl/irqv_regs.sv
`timescale 1ns/1ps
module irqv_regs
    import irqv_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  word_t             src_hi_i,
    input  word_t             src_lo_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  word_t             wdata_i,
    output word_t             en_hi_o,
    output word_t             en_lo_o,
    output word_t             pend_hi_o,
    output word_t             pend_lo_o
);
    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            case (addr_i)
                OFS_EN_HI:   st_d.en_hi   = wdata_i;
                OFS_EN_LO:   st_d.en_lo   = wdata_i;
                OFS_PEND_HI: st_d.pend_hi = st_q.pend_hi & ~wdata_i;
                OFS_PEND_LO: st_d.pend_lo = st_q.pend_lo & ~wdata_i;
                default: ;
            endcase
        end
        // level sources win over a same-cycle clear
        st_d.pend_hi = st_d.pend_hi | src_hi_i;
        st_d.pend_lo = st_d.pend_lo | src_lo_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign en_hi_o   = st_q.en_hi;
    assign en_lo_o   = st_q.en_lo;
    assign pend_hi_o = st_q.pend_hi;
    assign pend_lo_o = st_q.pend_lo;

    // R5
    src_sets_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (((st_q.pend_hi & $past(src_hi_i)) == $past(src_hi_i)) &&
                  ((st_q.pend_lo & $past(src_lo_i)) == $past(src_lo_i))));

    // R6
    clear_on_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == OFS_PEND_LO)
        |=> ((st_q.pend_lo & $past(wdata_i) & ~$past(src_lo_i)) == '0));

    // R6
    pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && (addr_i == OFS_PEND_HI || addr_i == OFS_PEND_LO))
        |=> ((($past(st_q.pend_hi) & ~st_q.pend_hi) == '0) &&
             (($past(st_q.pend_lo) & ~st_q.pend_lo) == '0)));

    // R4
    en_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == OFS_EN_HI) |=> (st_q.en_hi == $past(wdata_i)));

    // R10
    en_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && (addr_i == OFS_EN_HI || addr_i == OFS_EN_LO))
        |=> ($stable(st_q.en_hi) && $stable(st_q.en_lo)));
endmodule

// File: rtl/irqv_pick.sv
`timescale 1ns/1ps
module irqv_pick
    import irqv_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_VEC-1:0] act_i,
    output logic [VEC_W-1:0]   vec_o,
    output logic               any_o
);
    logic [VEC_W-1:0] sel_d;

    // scan from the top down so the lowest active vector is the last to land
    always_comb begin
        sel_d = '0;
        for (int i = NUM_VEC - 1; i >= 1; i--) begin
            if (act_i[i]) sel_d = VEC_W'(i);
        end
    end

    assign vec_o = sel_d;
    assign any_o = |act_i[NUM_VEC-1:1];

    // R8
    winner_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_o != '0) |-> act_i[vec_o]);

    // R8
    none_below_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_o != '0) |-> ((act_i & ((64'd1 << vec_o) - 64'd1) & ~64'd1) == 64'd0));

    // R9
    vec_zero_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_i[0] && act_i[NUM_VEC-1:1] == '0) |-> (vec_o == '0 && !any_o));
endmodule

// File: rtl/irqv_ctrl.sv
`timescale 1ns/1ps
module irqv_ctrl
    import irqv_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_VEC-1:0] src_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [WORD_W-1:0]  wdata_i,
    output logic [WORD_W-1:0]  rdata_o,
    output logic               irq_o
);
    word_t src_hi, src_lo;
    word_t en_hi, en_lo, pend_hi, pend_lo;
    logic [NUM_VEC-1:0] act_vec;
    logic [VEC_W-1:0]   vec;
    logic               any;

    irqv_map u_map (
        .src_i    (src_i),
        .act_hi_i (pend_hi & en_hi),
        .act_lo_i (pend_lo & en_lo),
        .src_hi_o (src_hi),
        .src_lo_o (src_lo),
        .act_o    (act_vec)
    );

    irqv_regs u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .src_hi_i  (src_hi),
        .src_lo_i  (src_lo),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .en_hi_o   (en_hi),
        .en_lo_o   (en_lo),
        .pend_hi_o (pend_hi),
        .pend_lo_o (pend_lo)
    );

    irqv_pick u_pick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .act_i  (act_vec),
        .vec_o  (vec),
        .any_o  (any)
    );

    always_comb begin
        case (addr_i)
            OFS_EN_HI:   rdata_o = en_hi;
            OFS_EN_LO:   rdata_o = en_lo;
            OFS_PEND_HI: rdata_o = pend_hi;
            OFS_PEND_LO: rdata_o = pend_lo;
            OFS_VEC:     rdata_o = {vec, {VEC_LSB{1'b0}}};
            default:     rdata_o = '0;
        endcase
    end

    assign irq_o = any;

    // R11
    irq_follows_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_i[1] && en_hi[15]) |=> irq_o);
endmodule

// File: tb/irqv_ctrl_tb_top.sv
`timescale 1ns/1ps
module irqv_ctrl_tb_top;
    localparam logic [4:0] A_EN_HI = 5'h00, A_EN_LO = 5'h04,
                           A_PD_HI = 5'h08, A_PD_LO = 5'h0C, A_VEC = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          total = 0;
    int          bad = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    irqv_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    function automatic void exp_loc(input int v, output bit hi, output int b);
        if (v < 16)      begin hi = 1'b1; b = (v == 0) ? 0 : 16 - v; end
        else if (v < 32) begin
            hi = 1'b0;
            case (v)
                16: b = 2;
                17: b = 1;
                31: b = 0;
                default: b = 15 - (v - 18);
            endcase
        end
        else if (v < 48) begin hi = 1'b1; b = 31 - (v - 32); end
        else             begin hi = 1'b0; b = 16 + (v - 48); end
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic clear_all();
        src = '0;
        wr(A_PD_HI, 32'hFFFF_FFFF);
        wr(A_PD_LO, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_EN_HI, d); check("R1 en_hi", d, 0);
        rd(A_EN_LO, d); check("R1 en_lo", d, 0);
        rd(A_PD_HI, d); check("R1 pend_hi", d, 0);
        rd(A_PD_LO, d); check("R1 pend_lo", d, 0);
        rd(A_VEC, d);   check("R1 vec", d, 0);
        check("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_map();
        logic [31:0] dh, dl;
        for (int v = 0; v < 64; v++) begin
            bit hi; int b;
            exp_loc(v, hi, b);
            src = 64'd1 << v;
            tick();
            rd(A_PD_HI, dh); rd(A_PD_LO, dl);
            // R2 bank choice, R3 bit position
            check($sformatf("R2 R3 v%0d hi", v), dh, hi ? (32'd1 << b) : 32'd0);
            check($sformatf("R2 R3 v%0d lo", v), dl, hi ? 32'd0 : (32'd1 << b));
            clear_all();
        end
        rd(A_PD_HI, dh); check("R6 all cleared hi", dh, 0);
        rd(A_PD_LO, dl); check("R6 all cleared lo", dl, 0);
    endtask

    task automatic t_enable_rw();
        logic [31:0] d;
        wr(A_EN_HI, 32'h1234_ABCD); rd(A_EN_HI, d); check("R4 en_hi rw", d, 32'h1234_ABCD);
        wr(A_EN_LO, 32'hF0F0_0F0F); rd(A_EN_LO, d); check("R4 en_lo rw", d, 32'hF0F0_0F0F);
        rd(A_EN_HI, d); check("R4 en_hi kept", d, 32'h1234_ABCD);
        wr(A_EN_HI, 0); wr(A_EN_LO, 0);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        wr(A_EN_HI, 32'hFFFF_FFFF); wr(A_EN_LO, 32'hFFFF_FFFF);
        src = (64'd1 << 5) | (64'd1 << 40) | (64'd1 << 20);
        #1; check("R11 irq before edge", {31'b0, irq}, 0);
        tick();
        check("R11 irq after edge", {31'b0, irq}, 1);
        rd(A_VEC, d); check("R8 vec 5", d, {6'd5, 26'd0});
        rd(A_VEC, d); check("R8 vec read no side effect", d, {6'd5, 26'd0});
        src[5] = 1'b0;
        wr(A_PD_HI, 32'hFFFF_FFFF); wr(A_PD_LO, 32'hFFFF_FFFF);
        rd(A_VEC, d); check("R8 vec 20", d, {6'd20, 26'd0});
        src[20] = 1'b0;
        wr(A_PD_LO, 32'hFFFF_FFFF);
        rd(A_VEC, d); check("R8 vec 40", d, {6'd40, 26'd0});
        src[40] = 1'b0;
        wr(A_PD_HI, 32'hFFFF_FFFF);
        rd(A_VEC, d); check("R8 vec none", d, 0);
        check("R9 irq low", {31'b0, irq}, 0);
        src = 64'd1; tick();
        rd(A_PD_HI, d); check("R9 v0 pending", d, 32'd1);
        rd(A_VEC, d);   check("R9 v0 not selected", d, 0);
        check("R9 v0 no irq", {31'b0, irq}, 0);
        src = 64'd1 << 63; tick();
        rd(A_VEC, d); check("R8 vec 63", d, {6'd63, 26'd0});
        check("R9 irq v63", {31'b0, irq}, 1);
        clear_all();
        wr(A_EN_HI, 0); wr(A_EN_LO, 0);
    endtask

    task automatic t_gate();
        logic [31:0] d;
        src = 64'd1 << 7; tick();
        rd(A_PD_HI, d); check("R5 disabled still pends", d, 32'd1 << 9);
        check("R9 disabled no irq", {31'b0, irq}, 0);
        rd(A_VEC, d); check("R8 disabled vec 0", d, 0);
        wr(A_EN_HI, 32'd1 << 9);
        check("R9 enable raises irq", {31'b0, irq}, 1);
        rd(A_VEC, d); check("R8 vec 7", d, {6'd7, 26'd0});
        wr(A_EN_HI, 0);
        check("R9 disable drops irq", {31'b0, irq}, 0);
        clear_all();
    endtask

    task automatic t_clear();
        logic [31:0] d;
        src = 64'd1 << 50; tick();
        rd(A_PD_LO, d); check("R5 v50 pending", d, 32'd1 << 18);
        wr(A_PD_LO, 0);
        rd(A_PD_LO, d); check("R6 zero write keeps", d, 32'd1 << 18);
        wr(A_PD_LO, 32'd1 << 18);
        rd(A_PD_LO, d); check("R7 level re-sets", d, 32'd1 << 18);
        src = '0;
        wr(A_PD_LO, 32'hFFFB_FFFF);
        rd(A_PD_LO, d); check("R6 other ones keep", d, 32'd1 << 18);
        wr(A_PD_LO, 32'd1 << 18);
        rd(A_PD_LO, d); check("R6 one write clears", d, 0);
    endtask

    task automatic t_ignore();
        logic [31:0] d;
        wr(A_EN_HI, 32'hA5A5_5A5A); wr(A_EN_LO, 32'h0000_FFFF);
        src = 64'd1 << 3; tick(); src = '0;
        wr(A_VEC, 32'hFFFF_FFFF); wr(5'h14, 32'hFFFF_FFFF); wr(5'h1C, 32'hFFFF_FFFF); wr(5'h02, 32'h0);
        rd(A_EN_HI, d); check("R10 en_hi untouched", d, 32'hA5A5_5A5A);
        rd(A_EN_LO, d); check("R10 en_lo untouched", d, 32'h0000_FFFF);
        rd(A_PD_HI, d); check("R10 pend_hi untouched", d, 32'd1 << 13);
        rd(5'h14, d);   check("R10 unmapped reads 0", d, 0);
        clear_all();
        wr(A_EN_HI, 0); wr(A_EN_LO, 0);
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_map();
        t_enable_rw();
        t_priority();
        t_gate();
        t_clear();
        t_ignore();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule